// File: doc/BRIEF.md
# Contextual Burst Address Generator

This block produces the register address for each word of a burst on a serial register interface. A burst begins when the framing logic pulses `start` with the first address. After that, every `next` pulse moves the address on to the following word. The serial framing and the register file itself are outside the block. It only turns a start address and a stream of advance strobes into a sequence of addresses.

In the plain mode every advance adds one. In the contextual mode a burst that lands in one of the two per-port data banks skips the ports that do not serve the access:

- A read in the converter-input bank visits only the ports that are marked as analog inputs.
- A write in the converter-output bank visits only the ports that are marked as analog outputs.

Reads of the output bank and writes of the input bank keep stepping by one. So does any address outside the two banks. When a skipping burst has no qualifying port left, the block raises `exhausted` and freezes the address. It does the same when a plain step would pass the top of the map.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `addr_o` is 0x00 and `exhausted_o` is 0. A `start` pulse loads `start_addr` into `addr_o` and clears `exhausted_o` in the following cycle. `start` takes priority over a simultaneous `next`.
- R2: With `ctx_mode` = 0, each `next` pulse increases `addr_o` by exactly 1 in the following cycle.
- R3: With `ctx_mode` = 1, an address outside both data banks still increases by 1 on `next`. The input bank is 0x40 + port and the output bank is 0x60 + port, for ports 0 to 19.
- R4: With `ctx_mode` = 1 and `is_write` = 0, `next` from an address in the input bank (0x40..0x53) moves to 0x40 + p. Here p is the lowest port above the current one whose bit `adc_mask[p]` is 1.
- R5: With `ctx_mode` = 1 and `is_write` = 1, `next` from an address in the output bank (0x60..0x73) moves to 0x60 + p. Here p is the lowest port above the current one whose bit `dac_mask[p]` is 1.
- R6: With `ctx_mode` = 1, a read in the output bank and a write in the input bank advance by 1.
- R7: The start address of a contextual burst is presented as given, even when its port is not configured.
- R8: When a contextual step finds no qualifying port above the current one, `exhausted_o` goes to 1 and `addr_o` keeps its value.
- R9: A step by one from an address at or above 0x73 sets `exhausted_o` to 1 and keeps `addr_o`.
- R10: While `exhausted_o` is 1, or while `next` is 0, `addr_o` and `exhausted_o` do not change until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load `start_addr` as the first word of a burst |
| start_addr | input | 7 | First register address of the burst |
| next | input | 1 | Advance to the following word |
| is_write | input | 1 | 1 for a write burst, 0 for a read burst |
| ctx_mode | input | 1 | 1 selects contextual skipping, 0 selects plain increment |
| adc_mask | input | 20 | Bit p set when port p is an analog input |
| dac_mask | input | 20 | Bit p set when port p is an analog output |
| addr_o | output | 7 | Address of the current burst word |
| exhausted_o | output | 1 | No further address exists for this burst |

## Verification
The bench targets the masks that hold a port in the highest slot, in the lowest slot, or none at all:

- A finder that picks the highest candidate rather than the lowest would jump over configured ports.
- A finder that includes the current index would stick on one address.

It runs every pairing of direction and bank in contextual mode. A decoder that ignores the direction would skip on output-bank reads.

It also starts bursts on unconfigured ports and at the top of the map. A design that skips the start word would show the wrong first address, and a missing bound would wrap into 0x74 or 0x00.

Random bursts then mix these cases under changing masks and modes.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
    localparam int ADDR_W   = 7;
    localparam int N_PORTS  = 20;
    localparam int ADC_BASE = 'h40;
    localparam int DAC_BASE = 'h60;
    localparam int MAX_ADDR = 'h73;
    localparam int IDX_W    = $clog2(N_PORTS);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              exhausted;
    } bag_state_t;
endpackage

// File: rtl/bank_decode.sv
module bank_decode #(
    parameter int ADDR_W  = 7,
    parameter int N_PORTS = 20,
    parameter int BASE    = 'h40,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + N_PORTS);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = addr - LO;
        hit    = (addr >= LO) && (addr < HI);
        idx    = offset[IDX_W-1:0];
    end
endmodule

// File: rtl/next_port_finder.sv
module next_port_finder #(
    parameter int N_PORTS = 20,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input  logic [N_PORTS-1:0] mask,
    input  logic [IDX_W-1:0]   cur,
    output logic               found,
    output logic [IDX_W-1:0]   nxt
);
    logic [N_PORTS-1:0] above;
    logic [N_PORTS-1:0] cand;

    // one comparator per port: is this port strictly above the current one
    for (genvar g = 0; g < N_PORTS; g++) begin : g_above
        assign above[g] = (IDX_W'(g) > cur);
    end

    assign cand = mask & above;

    // descending scan so that the lowest candidate is the last to be written
    always_comb begin
        found = 1'b0;
        nxt   = '0;
        for (int i = N_PORTS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                nxt   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int N_PORTS_P  = N_PORTS,
    parameter int ADC_BASE_P = ADC_BASE,
    parameter int DAC_BASE_P = DAC_BASE,
    parameter int MAX_ADDR_P = MAX_ADDR
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic                 next,
    input  logic                 is_write,
    input  logic                 ctx_mode,
    input  logic [N_PORTS_P-1:0] adc_mask,
    input  logic [N_PORTS_P-1:0] dac_mask,
    output logic [ADDR_W-1:0]    addr_o,
    output logic                 exhausted_o
);
    localparam int PIDX_W = $clog2(N_PORTS_P);

    bag_state_t st_d, st_q;

    logic                 adc_hit, dac_hit, found, ctx_apply;
    logic [PIDX_W-1:0]    adc_idx, dac_idx, cur_idx, nxt_idx;
    logic [N_PORTS_P-1:0] sel_mask;
    logic [ADDR_W-1:0]    sel_base;

    bank_decode #(.ADDR_W(ADDR_W), .N_PORTS(N_PORTS_P), .BASE(ADC_BASE_P)) adc_dec_i (
        .addr (st_q.addr),
        .hit  (adc_hit),
        .idx  (adc_idx)
    );

    bank_decode #(.ADDR_W(ADDR_W), .N_PORTS(N_PORTS_P), .BASE(DAC_BASE_P)) dac_dec_i (
        .addr (st_q.addr),
        .hit  (dac_hit),
        .idx  (dac_idx)
    );

    next_port_finder #(.N_PORTS(N_PORTS_P)) finder_i (
        .mask  (sel_mask),
        .cur   (cur_idx),
        .found (found),
        .nxt   (nxt_idx)
    );

    always_comb begin
        // bank-dependent selection feeding the finder
        sel_mask  = adc_hit ? adc_mask : dac_mask;
        cur_idx   = adc_hit ? adc_idx  : dac_idx;
        sel_base  = adc_hit ? ADDR_W'(ADC_BASE_P) : ADDR_W'(DAC_BASE_P);
        ctx_apply = ctx_mode && ((adc_hit && !is_write) || (dac_hit && is_write));

        st_d = st_q;
        if (start) begin
            st_d.addr      = start_addr;
            st_d.exhausted = 1'b0;
        end else if (next && !st_q.exhausted) begin
            if (ctx_apply) begin
                if (found) begin
                    st_d.addr = sel_base + ADDR_W'(nxt_idx);
                end else begin
                    st_d.exhausted = 1'b1;
                end
            end else if (st_q.addr >= ADDR_W'(MAX_ADDR_P)) begin
                st_d.exhausted = 1'b1;
            end else begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o      = st_q.addr;
    assign exhausted_o = st_q.exhausted;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_addr_pkg::*;
#(
    parameter int N_PORTS_P  = N_PORTS,
    parameter int ADC_BASE_P = ADC_BASE,
    parameter int DAC_BASE_P = DAC_BASE,
    parameter int MAX_ADDR_P = MAX_ADDR
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [ADDR_W-1:0]    start_addr,
    input logic                 next,
    input logic                 is_write,
    input logic                 ctx_mode,
    input logic [N_PORTS_P-1:0] adc_mask,
    input logic [N_PORTS_P-1:0] dac_mask,
    input logic [ADDR_W-1:0]    addr_o,
    input logic                 exhausted_o
);
    localparam int PIDX_W = $clog2(N_PORTS_P);

    logic [N_PORTS_P-1:0] adc_mask_q, dac_mask_q;
    logic                 in_adc, in_dac;
    logic [ADDR_W-1:0]    adc_off, dac_off;

    always_ff @(posedge clk) begin
        adc_mask_q <= adc_mask;
        dac_mask_q <= dac_mask;
    end

    always_comb begin
        in_adc  = (addr_o >= ADDR_W'(ADC_BASE_P)) && (addr_o < ADDR_W'(ADC_BASE_P + N_PORTS_P));
        in_dac  = (addr_o >= ADDR_W'(DAC_BASE_P)) && (addr_o < ADDR_W'(DAC_BASE_P + N_PORTS_P));
        adc_off = addr_o - ADDR_W'(ADC_BASE_P);
        dac_off = addr_o - ADDR_W'(DAC_BASE_P);
    end

    a_r1_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (addr_o == $past(start_addr)) && !exhausted_o);

    a_r2_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && next && !ctx_mode && !exhausted_o && addr_o < ADDR_W'(MAX_ADDR_P))
        |=> addr_o == $past(addr_o) + 1'b1);

    a_r4_adc_read_lands_on_input: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && next && ctx_mode && !is_write && in_adc && !exhausted_o)
        |=> exhausted_o || (in_adc && addr_o > $past(addr_o) && adc_mask_q[adc_off[PIDX_W-1:0]]));

    a_r5_dac_write_lands_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && next && ctx_mode && is_write && in_dac && !exhausted_o)
        |=> exhausted_o || (in_dac && addr_o > $past(addr_o) && dac_mask_q[dac_off[PIDX_W-1:0]]));

    a_r8_exhaust_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && $rose(exhausted_o)) |-> $stable(addr_o));

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && (!next || exhausted_o)) |=> $stable(addr_o) && $stable(exhausted_o));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .N_PORTS_P (N_PORTS_P),
    .ADC_BASE_P(ADC_BASE_P),
    .DAC_BASE_P(DAC_BASE_P),
    .MAX_ADDR_P(MAX_ADDR_P)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .next       (next),
    .is_write   (is_write),
    .ctx_mode   (ctx_mode),
    .adc_mask   (adc_mask),
    .dac_mask   (dac_mask),
    .addr_o     (addr_o),
    .exhausted_o(exhausted_o)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  start_addr = '0;
    logic        next = 1'b0;
    logic        is_write = 1'b0;
    logic        ctx_mode = 1'b0;
    logic [19:0] adc_mask = '0;
    logic [19:0] dac_mask = '0;
    logic [6:0]  addr_o;
    logic        exhausted_o;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [6:0] exp_addr = '0;
    logic       exp_ex = 1'b0;
    string      exp_tag;

    always #5 clk = ~clk;

    burst_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .next(next), .is_write(is_write), .ctx_mode(ctx_mode),
        .adc_mask(adc_mask), .dac_mask(dac_mask),
        .addr_o(addr_o), .exhausted_o(exhausted_o)
    );

    // reference step built from the requirement text
    task automatic model(input logic st, input logic [6:0] sa, input logic nx);
        logic in_adc, in_dac, hit;
        int   cur;
        in_adc = (exp_addr >= 7'h40) && (exp_addr <= 7'h53);
        in_dac = (exp_addr >= 7'h60) && (exp_addr <= 7'h73);
        if (st) begin
            exp_addr = sa; exp_ex = 1'b0; exp_tag = "R1";
        end else if (!nx || exp_ex) begin
            exp_tag = "R10";
        end else if (ctx_mode && ((in_adc && !is_write) || (in_dac && is_write))) begin
            cur = in_adc ? int'(exp_addr) - 'h40 : int'(exp_addr) - 'h60;
            hit = 1'b0;
            for (int p = cur + 1; p < 20; p++) begin
                if (!hit && (in_adc ? adc_mask[p] : dac_mask[p])) begin
                    hit = 1'b1;
                    exp_addr = 7'((in_adc ? 'h40 : 'h60) + p);
                end
            end
            if (!hit) begin exp_ex = 1'b1; exp_tag = "R8"; end
            else exp_tag = in_adc ? "R4" : "R5";
        end else if (exp_addr >= 7'h73) begin
            exp_ex = 1'b1; exp_tag = "R9";
        end else begin
            exp_addr = exp_addr + 1'b1;
            exp_tag = !ctx_mode ? "R2" : ((in_adc || in_dac) ? "R6" : "R3");
        end
    endtask

    task automatic compare(input string tag);
        n_checks++;
        if (addr_o !== exp_addr || exhausted_o !== exp_ex) begin
            n_fail++;
            $display("FAIL %s: addr=%h exh=%b expected addr=%h exh=%b",
                     tag, addr_o, exhausted_o, exp_addr, exp_ex);
        end
    endtask

    // inputs change at the falling edge; outputs are compared one falling edge later
    task automatic step(input logic st, input logic [6:0] sa, input logic nx, input string tag_ovr);
        start = st; start_addr = sa; next = nx;
        @(posedge clk);
        model(st, sa, nx);
        @(negedge clk);
        start = 1'b0; next = 1'b0;
        compare(tag_ovr.len() != 0 ? tag_ovr : exp_tag);
    endtask

    task automatic burst_cfg(input logic c, input logic w, input logic [19:0] am, input logic [19:0] dm);
        ctx_mode = c; is_write = w; adc_mask = am; dac_mask = dm;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_b1a5));
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R7 / R8 / R10: input-bank read, port 0 unconfigured, top port configured
        burst_cfg(1'b1, 1'b0, 20'h8_0088, 20'h0_0000);
        step(1'b1, 7'h40, 1'b0, "R7");
        step(1'b0, 7'h00, 1'b1, "R4");
        step(1'b0, 7'h00, 1'b1, "R4");
        step(1'b0, 7'h00, 1'b1, "R4");
        step(1'b0, 7'h00, 1'b1, "R8");
        step(1'b0, 7'h00, 1'b1, "R10");
        // R5 / R8: output-bank write
        burst_cfg(1'b1, 1'b1, 20'h0_0000, 20'h0_0024);
        step(1'b1, 7'h61, 1'b0, "R7");
        step(1'b0, 7'h00, 1'b1, "R5");
        step(1'b0, 7'h00, 1'b1, "R5");
        step(1'b0, 7'h00, 1'b1, "R8");
        // R8: empty mask exhausts at once
        burst_cfg(1'b1, 1'b1, 20'h0_0000, 20'h0_0000);
        step(1'b1, 7'h60, 1'b0, "R1");
        step(1'b0, 7'h00, 1'b1, "R8");
        // R6: output-bank read and input-bank write step by one
        burst_cfg(1'b1, 1'b0, 20'hF_FFFF, 20'h0_0000);
        step(1'b1, 7'h60, 1'b0, "R1");
        step(1'b0, 7'h00, 1'b1, "R6");
        burst_cfg(1'b1, 1'b1, 20'h0_0000, 20'h0_0000);
        step(1'b1, 7'h45, 1'b0, "R1");
        step(1'b0, 7'h00, 1'b1, "R6");
        // R3: outside banks in contextual mode
        step(1'b1, 7'h3F, 1'b0, "R1");
        step(1'b0, 7'h00, 1'b1, "R3");
        // R2 / R9: plain mode across the top of the map
        burst_cfg(1'b0, 1'b0, 20'hF_FFFF, 20'hF_FFFF);
        step(1'b1, 7'h72, 1'b0, "R1");
        step(1'b0, 7'h00, 1'b1, "R2");
        step(1'b0, 7'h00, 1'b1, "R9");
        step(1'b0, 7'h00, 1'b0, "R10");
        // R1: start wins over next in the same cycle
        step(1'b1, 7'h10, 1'b1, "R1");
        step(1'b0, 7'h00, 1'b0, "R10");

        // random bursts
        for (int k = 0; k < 4000; k++) begin
            logic st, nx;
            logic [6:0] sa;
            st = ($urandom % 10) == 0;
            nx = ($urandom % 4) != 0;
            sa = 7'(8'h38 + ($urandom % 8'h48));
            if (st) burst_cfg(1'($urandom), 1'($urandom), 20'($urandom), 20'($urandom));
            step(st, sa, nx, "");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule